// File: doc/BRIEF.md
# Shared Saturating Up/Down Bit Resolver

This block turns the noisy outputs of a small group of physically unclonable cells into stable bits. It serves the whole group with one saturating up/down counter, chosen per cell through a selection multiplexer. The cells are handled one after another. For each cell the counter is loaded with its midpoint. Each evaluation sample then moves the counter one step: up for a 1 and down for a 0. The walk ends when the counter reaches either absorbing end, or when a fixed number of trials has been used. Because of this, the number of trials differs from cell to cell.

The analog cell and its precharge and evaluation timing lie outside the block. The sample strobe marks the cycle in which the selected cell's output has settled and may be captured. After a start pulse, the block works through every cell and records two per-cell results: a resolved flag and the bit. It then pulses done for one cycle.

The controller is a state machine with five states:
- IDLE waits for start.
- LOAD reinitializes the counters for the selected cell.
- SAMPLE waits for a strobe and applies it.
- JUDGE decides whether the cell is finished.
- FINISH raises done.

Its transitions are:
- IDLE to LOAD on start.
- LOAD to SAMPLE always.
- SAMPLE to JUDGE on a strobe.
- JUDGE to SAMPLE when the cell is still open.
- JUDGE to LOAD when the cell is finished and more cells remain.
- JUDGE to FINISH when the last cell is finished.
- FINISH to IDLE always.

Top module: `puf_updown_voter`

## Requirements
- R1: After reset, the cell select is 0, every result and resolved bit is 0, and done is 0.
- R2: A start pulse in IDLE clears all results and resolved flags and begins with cell 0. A start pulse at any other time has no effect.
- R3: Before each cell, the vote counter is loaded with the midpoint (2^CNT_W − 2)/2 (7 for 4 bits). A strobe in SAMPLE raises the counter by one for a selected bit of 1 and lowers it by one for a 0. The counter never leaves the range 0 to 2^CNT_W − 2.
- R4: When the counter reaches 2^CNT_W − 2, the cell is recorded as resolved with result 1, and no further samples are taken for it.
- R5: When the counter reaches 0, the cell is recorded as resolved with result 0, and no further samples are taken for it.
- R6: A cell that reaches neither end within MAX_TRIALS samples (50 by default) is recorded as unresolved: resolved = 0 and result forced to 0. Reaching an end on an earlier trial still counts as resolved.
- R7: Cells are processed in ascending order. The cell select output shows the cell being sampled, and the selected bit is bit `cell_sel_o` of the cell input vector.
- R8: After the last cell is judged, done is high for exactly one cycle and the block returns to IDLE. With a strobe every cycle, done appears sum(1 + 2·T_i) clock edges after the edge that accepts start, where T_i is the number of trials used by cell i.
- R9: A strobe outside SAMPLE (in IDLE, LOAD, JUDGE or FINISH) has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a pass over all cells (accepted in IDLE only) |
| sample_stb_i | input | 1 | Selected cell output is settled and may be sampled |
| cell_bits_i | input | NUM_CELLS | Sampled outputs of the cells |
| cell_sel_o | output | SEL_W | Index of the cell currently being voted |
| result_o | output | NUM_CELLS | Resolved value per cell (0 when unresolved) |
| resolved_o | output | NUM_CELLS | Per-cell flag: 1 when an absorbing end was reached |
| done_o | output | 1 | One-cycle pulse when the pass is complete |

## Verification
Start is registered on the edge that sees it, so the counters are loaded one edge later. A strobe moves the counter on its own edge. The cell's result and the select advance appear on the following JUDGE edge, and done rises on the edge after the last judgement. The bench keeps a cycle-accurate behavioural model of that timing, advances it on each rising edge, and compares select, results, flags and done on every falling edge, away from the edge that changes them. Explicit checks cover the total latency of a fixed-pattern pass, the final bit patterns, the clearing on start and the single-cycle width of done.

// File: rtl/voter_pkg.sv
package voter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SAMPLE,
        ST_JUDGE,
        ST_FINISH
    } vstate_t;

endpackage

// File: rtl/vote_counter.sv
module vote_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             up_i,
    output logic [CNT_W-1:0] count_o,
    output logic             at_top_o,
    output logic             at_floor_o
);

    localparam logic [CNT_W-1:0] TOP_VAL = CNT_W'((2 ** CNT_W) - 2);
    localparam logic [CNT_W-1:0] MID_VAL = CNT_W'(((2 ** CNT_W) - 2) / 2);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= MID_VAL;
        end else if (load_i) begin
            count_q <= MID_VAL;
        end else if (step_i) begin
            if (up_i && (count_q != TOP_VAL)) begin
                count_q <= count_q + 1'b1;
            end else if (!up_i && (count_q != '0)) begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    assign count_o    = count_q;
    assign at_top_o   = (count_q == TOP_VAL);
    assign at_floor_o = (count_q == '0);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= TOP_VAL) else $error("count out of range"); // R3

    AST_LOAD_MID: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (count_q == MID_VAL)) else $error("load missed midpoint"); // R3

    AST_STEP_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(count_q)) else $error("count moved without step"); // R9

endmodule

// File: rtl/trial_counter.sv
module trial_counter #(
    parameter int MAX_TRIALS = 50,
    parameter int TR_W       = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            inc_i,
    output logic [TR_W-1:0] trials_o,
    output logic            at_limit_o
);

    localparam logic [TR_W-1:0] LIMIT = TR_W'(MAX_TRIALS);

    logic [TR_W-1:0] trials_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trials_q <= '0;
        end else if (clr_i) begin
            trials_q <= '0;
        end else if (inc_i && (trials_q != LIMIT)) begin
            trials_q <= trials_q + 1'b1;
        end
    end

    assign trials_o   = trials_q;
    assign at_limit_o = (trials_q == LIMIT);

    AST_TRIAL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        trials_q <= LIMIT) else $error("trial count past limit"); // R6

endmodule

// File: rtl/result_bank.sv
module result_bank #(
    parameter int NUM_CELLS = 4,
    parameter int SEL_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 wr_i,
    input  logic [SEL_W-1:0]     sel_i,
    input  logic                 ok_i,
    input  logic                 bit_i,
    output logic [NUM_CELLS-1:0] result_o,
    output logic [NUM_CELLS-1:0] resolved_o
);

    for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
        logic res_q;
        logic ok_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                res_q <= 1'b0;
                ok_q  <= 1'b0;
            end else if (clr_i) begin
                res_q <= 1'b0;
                ok_q  <= 1'b0;
            end else if (wr_i && (sel_i == SEL_W'(gi))) begin
                ok_q  <= ok_i;
                res_q <= ok_i & bit_i;
            end
        end

        assign result_o[gi]   = res_q;
        assign resolved_o[gi] = ok_q;
    end

    AST_UNRES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (result_o & ~resolved_o) == '0) else $error("unresolved cell with result 1"); // R6

endmodule

// File: rtl/puf_updown_voter.sv
module puf_updown_voter
    import voter_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int NUM_CELLS  = 4,
    parameter int MAX_TRIALS = 50,
    parameter int SEL_W      = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 sample_stb_i,
    input  logic [NUM_CELLS-1:0] cell_bits_i,
    output logic [SEL_W-1:0]     cell_sel_o,
    output logic [NUM_CELLS-1:0] result_o,
    output logic [NUM_CELLS-1:0] resolved_o,
    output logic                 done_o
);

    localparam int               TR_W     = $clog2(MAX_TRIALS + 1);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_CELLS - 1);

    vstate_t          state_q, state_d;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] vote_cnt;
    logic [TR_W-1:0]  trials;
    logic             at_top, at_floor, at_limit;
    logic             cell_bit;
    logic             cell_end, last_cell;
    logic             load_en, step_en, wr_en, clr_en, done_d;

    assign cell_bit  = cell_bits_i[sel_q];
    assign cell_end  = at_top | at_floor | at_limit;
    assign last_cell = (sel_q == LAST_SEL);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_SAMPLE;
            ST_SAMPLE: if (sample_stb_i) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (!cell_end)      state_d = ST_SAMPLE;
                else if (last_cell) state_d = ST_FINISH;
                else                state_d = ST_LOAD;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        load_en = 1'b0;
        step_en = 1'b0;
        wr_en   = 1'b0;
        clr_en  = 1'b0;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE:   clr_en  = start_i;
            ST_LOAD:   load_en = 1'b1;
            ST_SAMPLE: step_en = sample_stb_i;
            ST_JUDGE:  wr_en   = cell_end;
            ST_FINISH: done_d  = 1'b1;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (clr_en) begin
            sel_q <= '0;
        end else if (wr_en && !last_cell) begin
            sel_q <= sel_q + 1'b1;
        end
    end

    vote_counter #(.CNT_W(CNT_W)) u_vote (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_en),
        .step_i     (step_en),
        .up_i       (cell_bit),
        .count_o    (vote_cnt),
        .at_top_o   (at_top),
        .at_floor_o (at_floor)
    );

    trial_counter #(.MAX_TRIALS(MAX_TRIALS), .TR_W(TR_W)) u_trials (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (load_en),
        .inc_i      (step_en),
        .trials_o   (trials),
        .at_limit_o (at_limit)
    );

    result_bank #(.NUM_CELLS(NUM_CELLS), .SEL_W(SEL_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_en),
        .wr_i       (wr_en),
        .sel_i      (sel_q),
        .ok_i       (at_top | at_floor),
        .bit_i      (at_top),
        .result_o   (result_o),
        .resolved_o (resolved_o)
    );

    assign cell_sel_o = sel_q;
    assign done_o     = done_d;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R8

    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q <= LAST_SEL) else $error("select out of range"); // R7

    AST_SEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && cell_end && !last_cell) |=> (sel_q == $past(sel_q) + 1'b1))
        else $error("select did not advance"); // R7

    AST_TOP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && at_top) |=> (resolved_o[$past(sel_q)] && result_o[$past(sel_q)]))
        else $error("top end not recorded as 1"); // R4

    AST_FLOOR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE && at_floor) |=> (resolved_o[$past(sel_q)] && !result_o[$past(sel_q)]))
        else $error("floor end not recorded as 0"); // R5

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i && state_q != ST_FINISH) |=> (state_q != ST_IDLE))
        else $error("start disturbed a running pass"); // R2

endmodule

// File: tb/tb_puf_updown_voter.sv
module tb_puf_updown_voter;

    localparam int CLK_PERIOD = 10;
    localparam int NC         = 4;
    localparam int CW         = 4;
    localparam int MAXT       = 50;
    localparam int TOPV       = (2 ** CW) - 2;
    localparam int MIDV       = TOPV / 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic          stb;
    logic [NC-1:0] bits;
    logic [1:0]    sel;
    logic [NC-1:0] result;
    logic [NC-1:0] resolved;
    logic          done;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // stimulus controls
    int mode [NC];
    int stb_mode = 0;

    // behavioural model: 0 idle, 1 load, 2 sample, 3 judge, 4 finish
    int m_st = 0;
    int m_sel = 0;
    int m_cnt = MIDV;
    int m_tr = 0;
    bit [NC-1:0] m_res = '0;
    bit [NC-1:0] m_rsv = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    puf_updown_voter #(.CNT_W(CW), .NUM_CELLS(NC), .MAX_TRIALS(MAXT)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .sample_stb_i (stb),
        .cell_bits_i  (bits),
        .cell_sel_o   (sel),
        .result_o     (result),
        .resolved_o   (resolved),
        .done_o       (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    function automatic bit pattern(input int md, input int t);
        case (md)
            0: return 1'b1;
            1: return 1'b0;
            2: return 1'(t % 2);
            3: return (t < 42) ? 1'(t % 2) : 1'b1;
            4: return ($urandom_range(0, 3) != 0);
            default: return ($urandom_range(0, 3) == 0);
        endcase
    endfunction

    // model advance on every rising edge
    always @(posedge clk) begin
        bit fin;
        fin = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_cnt = MIDV; m_tr = 0; m_res = '0; m_rsv = '0;
        end else begin
            case (m_st)
                0: if (start) begin m_res = '0; m_rsv = '0; m_sel = 0; m_st = 1; end
                1: begin m_cnt = MIDV; m_tr = 0; m_st = 2; end
                2: if (stb) begin
                    if (bits[m_sel]) m_cnt = (m_cnt < TOPV) ? m_cnt + 1 : TOPV;
                    else             m_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
                    m_tr++;
                    m_st = 3;
                end
                3: begin
                    if (m_cnt == TOPV)      begin m_rsv[m_sel] = 1'b1; m_res[m_sel] = 1'b1; fin = 1'b1; end
                    else if (m_cnt == 0)    begin m_rsv[m_sel] = 1'b1; m_res[m_sel] = 1'b0; fin = 1'b1; end
                    else if (m_tr == MAXT)  fin = 1'b1;
                    else                    m_st = 2;
                    if (fin) begin
                        if (m_sel == NC - 1) m_st = 4;
                        else begin m_sel++; m_st = 1; end
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // compare and drive cell inputs on every falling edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check(sel == 2'(m_sel), "R7 select", sel, m_sel);
            check(result == m_res, "R4/R5 result", result, m_res);
            check(resolved == m_rsv, "R6 resolved", resolved, m_rsv);
            check(done == (m_st == 4), "R8 done", done, m_st == 4);
        end
        for (int i = 0; i < NC; i++)
            bits[i] = (i == m_sel) ? pattern(mode[i], m_tr) : 1'($urandom_range(0, 1));
        stb = (stb_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
    end

    task automatic run_pass(output int cyc, input int busy_start_at);
        @(negedge clk);
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            start = (cyc + 1 == busy_start_at);
            cyc++;
        end while (!done && cyc < 5000);
        start = 1'b0;
    endtask

    initial begin
        int cyc;
        rst_n = 1'b0; start = 1'b0; stb = 1'b0; bits = '0;
        for (int i = 0; i < NC; i++) mode[i] = 0;
        repeat (3) @(negedge clk);
        check(sel == 0, "R1 select", sel, 0);
        check(result == 0, "R1 result", result, 0);
        check(resolved == 0, "R1 resolved", resolved, 0);
        check(done == 0, "R1 done", done, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // pass A: const 1, const 0, alternating, boundary at trial 49
        mode[0] = 0; mode[1] = 1; mode[2] = 2; mode[3] = 3; stb_mode = 0;
        run_pass(cyc, 0);
        check(cyc == 231, "R8 latency", cyc, 231);
        check(result == 4'b1001, "R4/R5 final result", result, 4'b1001);
        check(resolved == 4'b1011, "R6 final resolved", resolved, 4'b1011);
        @(negedge clk);
        check(done == 0, "R8 single pulse", done, 0);

        // pass B: start clears, start while busy ignored
        mode[0] = 1; mode[1] = 0; mode[2] = 0; mode[3] = 1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(resolved == 0, "R2 clear on start", resolved, 0);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            start = (cyc == 10);
            cyc++;
        end
        start = 1'b0;
        check(result == 4'b0110, "R2 busy start result", result, 4'b0110);
        check(resolved == 4'b1111, "R2 busy start resolved", resolved, 4'b1111);

        // pass C: random bits, random strobe (R9 strobe outside SAMPLE)
        mode[0] = 4; mode[1] = 5; mode[2] = 4; mode[3] = 2; stb_mode = 1;
        run_pass(cyc, 0);
        check(done == 1, "R9 random pass completes", done, 1);
        check(resolved[3] == 0, "R6 alternating unresolved", resolved[3], 0);

        // pass D: boundary pattern on every cell with random strobe
        for (int i = 0; i < NC; i++) mode[i] = 3;
        run_pass(cyc, 0);
        check(resolved == 4'b1111, "R6 end on trial 49 resolves", resolved, 4'b1111);
        check(result == 4'b1111, "R4 boundary result", result, 4'b1111);

        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule